// File: doc/BRIEF.md
# Edge-Compensated Pulse Timestamper

This block gives the time of the rising edge of an external once-per-second pulse, measured on a local 16-bit time base. It has two counters that share one prescaler, so both advance once every four input clocks. The reference counter runs freely. The elapsed counter returns to zero when the synchronized pulse rises and then counts upward. Software can poll the block at any moment after the edge. The block then forms reference minus elapsed, which is the reference count at which the edge was registered. The polling delay drops out of the result.

A poll strobe captures the synchronized pulse level and both counters on the same clock edge. The captured level is the one that the elapsed counter has already acted upon, so a level can never be paired with a count from before its own edge. A timestamp is reported only when the captured level is high and the level captured at the previous enabled poll was low. An echo output follows the detected pulse state, with optional inversion. A mode enable gates all reporting.

Top module: `pps_stamper`

## Requirements
- R1: During and right after reset, `ts_valid` is 0, `ts_value` is 0, the internal echo state is inactive (so `echo_out` equals `echo_inv`), and the stored previous level is low.
- R2: The reference and elapsed counters advance together, once every DIV input clocks (DIV=4 by default). The first advance comes on the DIV-th clock edge after reset is released. Both wrap modulo 2^CNT_W.
- R3: `pulse_in` passes through a two-flop synchronizer. A rising level sampled on clock edge k restarts the elapsed counter at edge k+2.
- R4: When `poll` and `mode_en` are high on an edge, the captured level is high, and the previous captured level was low, `ts_valid` is 1 for exactly the one following cycle. At all other times `ts_valid` is 0.
- R5: With an event, `ts_value` equals the reference count at the edge where the elapsed counter restarted, modulo 2^CNT_W. That is floor((k+2)/DIV) mod 2^CNT_W, where k is the edge that first sampled the high level and edges are counted from reset release. `ts_value` holds between events.
- R6: A poll on an edge where the synchronized rise has not yet reached the elapsed counter reports no event. A later poll reports that edge with the correct timestamp.
- R7: A reported assertion sets the echo state active. A poll that captures low after a high sets it inactive. `echo_out` is the echo state XOR `echo_inv`.
- R8: While `mode_en` is 0, polls report nothing, the echo state holds, and the previous level is not updated. An edge that arrives while the mode is disabled is therefore reported at the first enabled poll.
- R9: If the pulse stays high long enough for the elapsed counter to wrap, the timestamp is still exact modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse input |
| poll | input | 1 | Poll strobe, one cycle |
| mode_en | input | 1 | Enables event reporting and echo updates |
| echo_inv | input | 1 | Inverts the echo output |
| ts_valid | output | 1 | One-cycle event strobe after a poll |
| ts_value | output | CNT_W | Timestamp of the last reported edge |
| echo_out | output | 1 | Echo of the detected pulse state |

## Verification
Two functions can fall in the same cycle: a poll, and the synchronized rise that restarts the elapsed counter. The bench raises the pulse and then sweeps the poll delay cycle by cycle across this window, so that some polls land before the restart and some after it. It expects no event on the early polls and an exact reference-minus-elapsed stamp on the first poll at or after the restart. The counter advance tick moves through every phase of the sweep, and the bench computes each expected stamp from its own count of edges since reset.

// File: rtl/pps_stamper.sv
module pps_stamper #(
  parameter int CNT_W = 16,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             poll,
  input  logic             mode_en,
  input  logic             echo_inv,
  output logic             ts_valid,
  output logic [CNT_W-1:0] ts_value,
  output logic             echo_out
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0]    div_q;
  logic [CNT_W-1:0] ref_q, ela_q;
  logic             s1_q, s2_q, s3_q;
  logic             prev_q, echo_q;

  wire tick   = (div_q == DW'(DIV - 1));
  wire rise   = s2_q & ~s3_q;
  wire take   = poll & mode_en;
  wire ev_up  = take & s3_q & ~prev_q;
  wire ev_dn  = take & ~s3_q & prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ref_q <= '0;
      ela_q <= '0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      s1_q  <= pulse_in;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      if (tick) ref_q <= ref_q + 1'b1;
      if (rise)      ela_q <= '0;
      else if (tick) ela_q <= ela_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      echo_q   <= 1'b0;
      ts_valid <= 1'b0;
      ts_value <= '0;
    end else begin
      ts_valid <= ev_up;
      if (take)  prev_q   <= s3_q;
      if (ev_up) begin
        ts_value <= ref_q - ela_q;
        echo_q   <= 1'b1;
      end
      if (ev_dn) echo_q <= 1'b0;
    end
  end

  assign echo_out = echo_q ^ echo_inv;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ts_valid |=> !ts_valid); // R4
  AST_VALID_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n) ts_valid |-> $past(poll && mode_en)); // R4
  AST_ELAPSED_RESTART: assert property (@(posedge clk) disable iff (!rst_n) $rose(s3_q) |-> (ela_q == '0)); // R3
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ts_valid |-> $stable(ts_value)); // R5
  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(mode_en) |-> $stable(echo_q)); // R8
  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !$past(tick) |-> $stable(ref_q)); // R2
endmodule

// File: tb/pps_stamper_tb.sv
module pps_stamper_tb_top;
  localparam int W   = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0, poll = 1'b0, mode_en = 1'b1, echo_inv = 1'b0;
  logic ts_valid, echo_out;
  logic [W-1:0] ts_value;

  int checks = 0, fails = 0, cyc = 0, m = 0;
  logic [W-1:0] expv, held;

  pps_stamper #(.CNT_W(W), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .poll(poll),
    .mode_en(mode_en), .echo_inv(echo_inv), .ts_valid(ts_valid),
    .ts_value(ts_value), .echo_out(echo_out));

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic do_poll();
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
  endtask

  function automatic logic [W-1:0] stamp(input int mm);
    return W'(((mm + 3) / DIV) % (1 << W));
  endfunction

  task automatic expect_event(input string tag);
    chk(ts_valid === 1'b1, {tag, " valid"}, int'(ts_valid), 1);
    chk(ts_value === expv, {tag, " value"}, int'(ts_value), int'(expv));
    @(negedge clk);
    chk(ts_valid === 1'b0, "R4 one-cycle valid", int'(ts_valid), 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ts_valid === 1'b0, "R1 reset valid", int'(ts_valid), 0);
    chk(ts_value === '0, "R1 reset value", int'(ts_value), 0);
    chk(echo_out === 1'b0, "R1 reset echo", int'(echo_out), 0);
    rst_n = 1'b1;

    for (int inv = 0; inv < 2; inv++) begin
      echo_inv = inv[0];
      for (int d = 0; d < 12; d++) begin
        repeat (d + 1) @(negedge clk);
        pulse_in = 1'b1;
        m = cyc;
        expv = stamp(m);
        repeat (d) @(negedge clk);
        do_poll();
        if (d >= 3) begin
          expect_event("R5 stamp");
        end else begin
          chk(ts_valid === 1'b0, "R6 early poll no event", int'(ts_valid), 0);
          repeat (4) @(negedge clk);
          do_poll();
          expect_event("R6 late poll stamp");
        end
        chk(echo_out === ~inv[0], "R7 echo active", int'(echo_out), int'(~inv[0]));
        held = ts_value;
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        do_poll();
        chk(ts_valid === 1'b0, "R4 no event on low", int'(ts_valid), 0);
        chk(ts_value === held, "R5 value holds", int'(ts_value), int'(held));
        chk(echo_out === inv[0], "R7 echo inactive", int'(echo_out), int'(inv[0]));
        do_poll();
        chk(ts_valid === 1'b0, "R4 repeated low poll", int'(ts_valid), 0);
      end
    end
    echo_inv = 1'b0;

    // R8: disabled mode
    mode_en = 1'b0;
    @(negedge clk);
    pulse_in = 1'b1;
    m = cyc;
    expv = stamp(m);
    repeat (8) @(negedge clk);
    do_poll();
    chk(ts_valid === 1'b0, "R8 disabled no event", int'(ts_valid), 0);
    chk(echo_out === 1'b0, "R8 echo holds", int'(echo_out), 0);
    repeat (3) @(negedge clk);
    mode_en = 1'b1;
    do_poll();
    expect_event("R8 deferred stamp");
    mode_en = 1'b0;
    pulse_in = 1'b0;
    repeat (6) @(negedge clk);
    do_poll();
    chk(echo_out === 1'b1, "R8 echo holds high", int'(echo_out), 1);
    mode_en = 1'b1;
    do_poll();
    chk(echo_out === 1'b0, "R7 echo drops when enabled", int'(echo_out), 0);

    // R9 and R2: elapsed wraps while the pulse stays high
    pulse_in = 1'b1;
    m = cyc;
    expv = stamp(m);
    repeat (DIV * (1 << W) + 777) @(negedge clk);
    do_poll();
    expect_event("R9 wrapped stamp");
    pulse_in = 1'b0;
    repeat (5) @(negedge clk);
    do_poll();

    // R2: stamps at every prescaler phase over many counter wraps
    for (int k = 0; k < 40; k++) begin
      repeat (311 + k) @(negedge clk);
      pulse_in = 1'b1;
      m = cyc;
      expv = stamp(m);
      repeat (5 + (k % 4)) @(negedge clk);
      do_poll();
      expect_event("R2 counter rate");
      pulse_in = 1'b0;
      repeat (4) @(negedge clk);
      do_poll();
    end

    // R3: edge shorter than sync latency polled right at the boundary
    pulse_in = 1'b1;
    m = cyc;
    expv = stamp(m);
    repeat (2) @(negedge clk);
    do_poll();
    chk(ts_valid === 1'b0, "R3 two-flop latency", int'(ts_valid), 0);
    do_poll();
    expect_event("R3 restart edge");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule